// File: doc/BRIEF.md
# Autobaud Clock Enable Generator

This block listens to an idle-high asynchronous serial receive line and learns the bit period from a carriage-return character (0x0D) typed at a terminal. The frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Bit 0 of 0x0D is 1, so the low time of the start bit is exactly one bit period. The block counts that low time in system clock cycles. It then samples the rest of the frame at the measured spacing, and accepts the measurement only if that pattern matches a carriage return.

Once a measurement is accepted, the block produces a one-cycle clock-enable pulse. The pulse repeats at `FACTOR` times the detected bit rate, so a serial transmitter and receiver elsewhere in the chip can share it as their oversampling strobe. The period in system clocks is the measured bit time shifted right by log2(`FACTOR`). `FACTOR` must be a power of two.

Measurement keeps running after lock. A new carriage return at a different rate retunes the pulse without a reset. Any rejected measurement leaves the running rate and the lock flag as they were. The serial input passes through a two-flop synchroniser. The asynchronous active-low reset is released through its own two-flop synchroniser.

Top module: `autobaud_tick_gen`

## Requirements
- R1: After reset, `locked` is 0 and `tick_en` is 0. `tick_en` stays 0 for as long as `locked` is 0.
- R2: A carriage return is accepted when its start bit is low for T system clocks, with FACTOR <= T <= 2^CNT_W - 1. After it is accepted, `locked` is 1 and rising `tick_en` pulses are exactly floor(T / FACTOR) clocks apart.
- R3: Each `tick_en` pulse is one clock wide whenever the period is greater than one clock.
- R4: Another accepted carriage return at a different bit time replaces the pulse period with the new floor(T / FACTOR), with no reset needed.
- R5: The bits after the start bit are sampled at mid-bit with the measured spacing. The expected values, in time order, are 0,1,1,0,0,0,0,1, which is data bits 1..7 of 0x0D followed by the stop bit. If any sample differs, the period and `locked` are left unchanged.
- R6: If the line stays low for 2^CNT_W or more clocks, the measurement is abandoned. This holds even when the tail that follows would form a valid carriage return at the wrapped count. The period and `locked` are left unchanged.
- R7: A carriage return whose start bit is shorter than FACTOR clocks, which would give a zero period, is rejected. The period and `locked` are left unchanged.
- R8: Once `locked` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Serial receive line, idle high, asynchronous to clk |
| tick_en | output | 1 | One-clock enable pulse at FACTOR times the learned bit rate |
| locked | output | 1 | High once a carriage return has been accepted |

## Verification
The hardest case to reach from the ports is a low pulse longer than the counter range whose tail is otherwise a perfect carriage return. If the count silently wrapped, that input would retune the block. The stimulus holds the line low for exactly 2^CNT_W plus 80 clocks and then sends the remaining bits of 0x0D at 80 clocks per bit. A wrapping counter would lock to a period of 10 while the block is already running at 20. A non-carriage-return character whose first data bit is 1 exercises pattern rejection in a second way: its start bit measures correctly, and only the later samples tell it apart.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  typedef enum logic [1:0] {
    AB_IDLE  = 2'd0,
    AB_MEAS  = 2'd1,
    AB_CHECK = 2'd2
  } ab_state_e;

  // carriage return framed as stop, data (msb..lsb), start
  localparam logic [9:0] AB_SYNC_FRAME = {1'b1, 8'h0D, 1'b0};

  // samples expected after the start bit and data bit 0, oldest in bit 0
  localparam logic [7:0] AB_CHECK_PAT = AB_SYNC_FRAME[9:2];

endpackage

// File: rtl/ab_sync2.sv
module ab_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/ab_measure.sv
module ab_measure
  import autobaud_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FACTOR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_s,
  output logic             upd,
  output logic [CNT_W-1:0] new_div
);

  localparam int                SH      = $clog2(FACTOR);
  localparam int                TMR_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [TMR_W-1:0]  TMR_ONE = TMR_W'(1);

  ab_state_e        st_q, st_n;
  logic             rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] per_q, per_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic [2:0]       idx_q, idx_n;

  assign new_div = per_q >> SH;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    per_n = per_q;
    tmr_n = tmr_q;
    idx_n = idx_q;
    upd   = 1'b0;
    unique case (st_q)
      AB_IDLE: begin
        if (rx_d && !rx_s) begin
          st_n  = AB_MEAS;
          cnt_n = CNT_ONE;
        end
      end
      AB_MEAS: begin
        if (!rx_s) begin
          if (cnt_q == CNT_MAX) st_n = AB_IDLE;
          else                  cnt_n = cnt_q + CNT_ONE;
        end else begin
          per_n = cnt_q;
          tmr_n = {1'b0, cnt_q} + {2'b00, cnt_q[CNT_W-1:1]};
          idx_n = 3'd0;
          st_n  = AB_CHECK;
        end
      end
      AB_CHECK: begin
        if (tmr_q > TMR_ONE) begin
          tmr_n = tmr_q - TMR_ONE;
        end else if (rx_s != AB_CHECK_PAT[idx_q]) begin
          st_n = AB_IDLE;
        end else if (idx_q == 3'd7) begin
          st_n = AB_IDLE;
          upd  = (new_div != '0);
        end else begin
          idx_n = idx_q + 3'd1;
          tmr_n = {1'b0, per_q};
        end
      end
      default: st_n = AB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AB_IDLE;
      rx_d  <= 1'b1;
      cnt_q <= '0;
      per_q <= '0;
      tmr_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_n;
      rx_d  <= rx_s;
      cnt_q <= cnt_n;
      per_q <= per_n;
      tmr_q <= tmr_n;
      idx_q <= idx_n;
    end
  end

  // R6: while the line is low the count advances by exactly one per clock
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AB_MEAS && !rx_s && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R6: a low time that fills the counter abandons the measurement
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AB_MEAS && !rx_s && cnt_q == CNT_MAX) |=> (st_q == AB_IDLE));

  // R5: an update only follows a full pattern check
  a_r5_update_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (st_q == AB_CHECK && idx_q == 3'd7));

endmodule

// File: rtl/ab_tick_gen.sv
module ab_tick_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_div,
  output logic             tick_en,
  output logic             locked
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] ph_q, ph_n;
  logic             lock_n, tick_n;

  always_comb begin
    div_n  = div_q;
    ph_n   = ph_q;
    lock_n = locked;
    tick_n = 1'b0;
    if (load) begin
      div_n  = load_div;
      ph_n   = '0;
      lock_n = 1'b1;
    end else if (locked) begin
      if (ph_q >= div_q - ONE) begin
        ph_n   = '0;
        tick_n = 1'b1;
      end else begin
        ph_n = ph_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ph_q    <= '0;
      locked  <= 1'b0;
      tick_en <= 1'b0;
    end else begin
      div_q   <= div_n;
      ph_q    <= ph_n;
      locked  <= lock_n;
      tick_en <= tick_n;
    end
  end

  // R1: no enable pulse before a rate is known
  a_r1_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !tick_en);

  // R3: pulses are a single clock wide when the period exceeds one
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && div_q > ONE) |=> !tick_en);

  // R8: lock is held until reset
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R2: a locked generator never runs with a zero period
  a_r2_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (div_q != '0));

endmodule

// File: rtl/autobaud_tick_gen.sv
module autobaud_tick_gen #(
  parameter int CNT_W  = 16,
  parameter int FACTOR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic tick_en,
  output logic locked
);

  logic             rst_sync_n;
  logic             rx_s;
  logic             upd;
  logic [CNT_W-1:0] new_div;

  ab_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  ab_sync2 #(.RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (rx_line),
    .q     (rx_s)
  );

  ab_measure #(.CNT_W(CNT_W), .FACTOR(FACTOR)) u_measure (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_s    (rx_s),
    .upd     (upd),
    .new_div (new_div)
  );

  ab_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (upd),
    .load_div (new_div),
    .tick_en  (tick_en),
    .locked   (locked)
  );

endmodule

// File: tb/test_autobaud_tick_gen.sv
`timescale 1ns/1ps
module test_autobaud_tick_gen;

  localparam int CNT_W  = 10;
  localparam int FACTOR = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_line;
  logic tick_en;
  logic locked;

  always #2.5 clk = ~clk;

  autobaud_tick_gen #(.CNT_W(CNT_W), .FACTOR(FACTOR)) i_autobaud_tick_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_line (rx_line),
    .tick_en (tick_en),
    .locked  (locked)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  // reference model state
  bit    care      = 1'b0;
  bit    exp_lock  = 1'b0;
  int    exp_div   = 0;
  string cur_req   = "R1";
  bit    have_last = 1'b0;
  bit    prev_tick = 1'b0;
  int    last_tick = 0;
  int    cyc       = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d",
               req, what, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int t);
    hold(1'b0, t);
    for (int i = 0; i < 8; i++) hold(b[i], t);
    hold(1'b1, t);
  endtask

  // cycle-by-cycle comparison against the behavioural expectation
  always @(posedge clk) begin
    #1;
    cyc++;
    if (care) begin
      chk(locked == exp_lock, cur_req, "locked", int'(locked), int'(exp_lock));
      if (tick_en && !exp_lock)
        chk(1'b0, "R1", "tick while unlocked", 1, 0);
      if (tick_en && prev_tick && exp_div > 1)
        chk(1'b0, "R3", "tick width", 2, 1);
      if (tick_en) begin
        if (have_last)
          chk((cyc - last_tick) == exp_div, cur_req, "tick period",
              cyc - last_tick, exp_div);
        have_last = 1'b1;
        last_tick = cyc;
      end
    end else begin
      have_last = 1'b0;
    end
    prev_tick = tick_en;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      summary();
      $finish;
    end
  end

  // retune: frame at bit time t, then expect period t/FACTOR
  task automatic retune(input int t, input string req);
    care = 1'b0;
    send_frame(8'h0D, t);
    idle(4);
    exp_lock = 1'b1;
    exp_div  = t / FACTOR;
    cur_req  = req;
    care     = 1'b1;
    idle(30 * exp_div);
    chk(locked == 1'b1, req, "locked after carriage return", int'(locked), 1);
  endtask

  initial begin
    rx_line = 1'b1;
    rst_n   = 1'b0;
    repeat (5) @(negedge clk);
    chk(locked == 1'b0, "R1", "locked in reset", int'(locked), 0);
    chk(tick_en == 1'b0, "R1", "tick in reset", int'(tick_en), 0);
    rst_n = 1'b1;
    idle(4);
    chk(locked == 1'b0, "R1", "locked after reset", int'(locked), 0);

    exp_lock = 1'b0;
    exp_div  = 0;
    cur_req  = "R1";
    care     = 1'b1;
    idle(200);

    // R5: 0x55 measures a valid start bit but fails the third sample
    cur_req = "R5";
    send_frame(8'h55, 80);
    idle(200);
    chk(locked == 1'b0, "R5", "locked after other char", int'(locked), 0);

    // R2: first lock, bit time 80 -> period 10
    retune(80, "R2");

    // R4: new rate without reset, bit time 160 -> period 20
    retune(160, "R4");

    // R6: overlong low, tail that would lock to period 10 if count wrapped
    cur_req = "R6";
    hold(1'b0, (1 << CNT_W) + 80);
    for (int i = 0; i < 8; i++) hold(8'h0D >> i & 8'h01, 80);
    hold(1'b1, 80);
    idle(600);
    chk(locked == 1'b1, "R6", "locked after overlong low", int'(locked), 1);

    // R5: mismatching char while locked, different spacing
    cur_req = "R5";
    send_frame(8'h55, 120);
    idle(600);

    // R7: start bit shorter than FACTOR
    cur_req = "R7";
    send_frame(8'h0D, 6);
    idle(600);
    chk(locked == 1'b1, "R7", "locked after short char", int'(locked), 1);

    // R2: odd bit time truncates, 85 -> 10
    retune(85, "R2");

    // R4: faster rate, 48 -> 6
    retune(48, "R4");

    // R8: lock held through a long idle stretch
    cur_req = "R8";
    idle(300);
    chk(locked == 1'b1, "R8", "lock held", int'(locked), 1);

    care = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule